// File: doc/BRIEF.md
# Programmable Interval Interrupt Timer

This block is a small register-programmed timer with a byte-wide bus. Software sets a 24-bit interval and a two-bit control word. While the run bit is set, the block counts cycles on which the `tick` input is high. When the count reaches the interval, the block emits a single-cycle interrupt request and starts counting again from zero. It keeps doing this until software clears the run bit.

A control bit chooses which line carries the request: the maskable line `irq_pulse` or the non-maskable line `nmi_pulse`. Software writes the interval one byte at a time, and each write changes only the addressed byte. The counter is cleared only when the run bit goes from 0 to 1. Writing the control word again while the timer already runs leaves the count unchanged. All registers can be read back through the same bus as combinational data selected by `addr`.

Top module: `tick_timer`

## Requirements
- R1: After reset, all four offsets read 0x00 and neither pulse output is high.
- R2: A write to offset 0 sets run from data bit 0 and the request kind from data bit 1 (1 = non-maskable, 0 = maskable). A read of offset 0 returns those two bits in the same positions, and the other bits read 0.
- R3: Offsets 1, 2 and 3 hold interval bits 7:0, 15:8 and 23:16. A write to one offset replaces only that byte. A read returns the stored byte.
- R4: While run is set, the count advances by one on each cycle that `tick` is high. Cycles with `tick` low do not change the count.
- R5: When a tick brings the count to the nonzero interval, one request pulse is high in the cycle after that tick, and the count restarts from zero. An interval of N therefore gives one pulse every N ticks.
- R6: With the kind bit at 1, matches pulse only `nmi_pulse`. With the kind bit at 0, they pulse only `irq_pulse`.
- R7: A control write that changes run from 0 to 1 clears the count, and any tick in that same cycle is not counted. A control write with run at 1 while already running keeps the count.
- R8: While run is 0, ticks produce no pulse on either line.
- R9: An interval of zero never produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-enable strobe, one count per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| irq_pulse | output | 1 | One-cycle maskable request |
| nmi_pulse | output | 1 | One-cycle non-maskable request |

## Verification
The bench records the exact tick at which each pulse appears. This catches an off-by-one match, which would fire at tick N-1 or N+1, and a missing reload, which would give a single pulse and then silence. It rewrites the control word mid-count while the timer runs, then stops and restarts the timer. A design that cleared on every control write, or never cleared, would put the next pulse at the wrong tick. It also spaces ticks with idle cycles, holds the timer disabled, and programs a zero interval; a design that counted clock cycles or matched on zero would raise stray requests. Finally, it rewrites a single interval byte and checks the other two, which catches a write that spills into the neighbouring bytes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_NMI_BIT = 1;

    typedef struct packed {
        logic to_nmi;
        logic run;
    } tmr_ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int INTV_BYTES = 3,
    localparam int CNT_W     = BYTE_W * INTV_BYTES,
    localparam int ADDR_W    = $clog2(INTV_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              run_o,
    output logic              to_nmi_o,
    output logic [CNT_W-1:0]  intv_o,
    output logic              start_o
);
    typedef struct packed {
        tmr_ctrl_t        ctrl;
        logic [CNT_W-1:0] intv;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  start_d;

    always_comb begin
        regs_d  = regs_q;
        start_d = 1'b0;
        if (wr_en) begin
            if (addr == '0) begin
                regs_d.ctrl.run    = wr_data[CTRL_RUN_BIT];
                regs_d.ctrl.to_nmi = wr_data[CTRL_NMI_BIT];
                start_d            = wr_data[CTRL_RUN_BIT] && !regs_q.ctrl.run;
            end
            for (int k = 0; k < INTV_BYTES; k++) begin
                if (addr == ADDR_W'(k + 1))
                    regs_d.intv[k*BYTE_W +: BYTE_W] = wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == '0) begin
            rd_data[CTRL_RUN_BIT] = regs_q.ctrl.run;
            rd_data[CTRL_NMI_BIT] = regs_q.ctrl.to_nmi;
        end
        for (int k = 0; k < INTV_BYTES; k++) begin
            if (addr == ADDR_W'(k + 1))
                rd_data = regs_q.intv[k*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign run_o    = regs_q.ctrl.run;
    assign to_nmi_o = regs_q.ctrl.to_nmi;
    assign intv_o   = regs_q.intv;
    assign start_o  = start_d;

    // R2
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0) |=> (run_o == $past(wr_data[CTRL_RUN_BIT])) &&
                                  (to_nmi_o == $past(wr_data[CTRL_NMI_BIT])));
    // R3
    low_byte_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(1)) |=> (intv_o[BYTE_W-1:0] == $past(wr_data)) &&
                                          $stable(intv_o[CNT_W-1:BYTE_W]));
    // R7
    start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !run_o);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             to_nmi_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] intv_i,
    output logic             irq_o,
    output logic             nmi_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             nmi;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] inc;

    always_comb begin
        inc        = st_q.cnt + 1'b1;
        st_d       = st_q;
        st_d.irq   = 1'b0;
        st_d.nmi   = 1'b0;
        if (start_i) begin
            st_d.cnt = '0;
        end else if (run_i && tick_i) begin
            if (intv_i != '0 && inc == intv_i) begin
                st_d.cnt = '0;
                st_d.nmi = to_nmi_i;
                st_d.irq = !to_nmi_i;
            end else begin
                st_d.cnt = inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;
    assign nmi_o = st_q.nmi;

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !start_i && intv_i != st_q.cnt + 1'b1) |=>
            (st_q.cnt == $past(st_q.cnt) + 1'b1));
    // R5
    pulse_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || nmi_o) |-> (st_q.cnt == '0));
    // R6
    kind_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !to_nmi_i) |=> !nmi_o);
    // R7
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q.cnt == '0) && !irq_o && !nmi_o);
    // R8
    idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_i && tick_i) |=> !(irq_o || nmi_o));
    // R9
    zero_intv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (intv_i == '0) |=> !(irq_o || nmi_o));
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int BYTE_W     = 8,
    parameter int INTV_BYTES = 3,
    localparam int CNT_W     = BYTE_W * INTV_BYTES,
    localparam int ADDR_W    = $clog2(INTV_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              irq_pulse,
    output logic              nmi_pulse
);
    logic             run, to_nmi, start;
    logic [CNT_W-1:0] intv;

    tmr_regs #(.BYTE_W(BYTE_W), .INTV_BYTES(INTV_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .run_o(run),
        .to_nmi_o(to_nmi), .intv_o(intv), .start_o(start)
    );

    tmr_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .run_i(run),
        .to_nmi_i(to_nmi), .start_i(start), .intv_i(intv),
        .irq_o(irq_pulse), .nmi_o(nmi_pulse)
    );

    // R6
    single_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_pulse && nmi_pulse));
endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_pulse, nmi_pulse;
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    tick_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data),
        .irq_pulse(irq_pulse), .nmi_pulse(nmi_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    // Apply n ticks with gap idle cycles after each; record pulses per tick.
    task automatic run_ticks(input int n, input int gap,
                             output int irqs, output int nmis,
                             output int first, output int last, output int stray);
        irqs = 0; nmis = 0; first = 0; last = 0; stray = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            if (irq_pulse || nmi_pulse) begin
                if (first == 0) first = i;
                last = i;
            end
            if (irq_pulse) irqs++;
            if (nmi_pulse) nmis++;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                if (irq_pulse || nmi_pulse) stray++;
            end
        end
    endtask

    task automatic set_intv(input int v);
        wr(2'd1, v[7:0]); wr(2'd2, v[15:8]); wr(2'd3, v[23:16]);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            check(d == 8'h00, "R1 reset readback", d, 0);
        end
        check(!irq_pulse && !nmi_pulse, "R1 reset pulses", irq_pulse + nmi_pulse, 0);
    endtask

    task automatic t_regs;
        logic [7:0] d;
        set_intv(24'hA1B2C3);
        rd(2'd1, d); check(d == 8'hC3, "R3 byte0", d, 8'hC3);
        rd(2'd2, d); check(d == 8'hB2, "R3 byte1", d, 8'hB2);
        rd(2'd3, d); check(d == 8'hA1, "R3 byte2", d, 8'hA1);
        wr(2'd2, 8'h5E);
        rd(2'd1, d); check(d == 8'hC3, "R3 byte0 kept", d, 8'hC3);
        rd(2'd2, d); check(d == 8'h5E, "R3 byte1 new", d, 8'h5E);
        rd(2'd3, d); check(d == 8'hA1, "R3 byte2 kept", d, 8'hA1);
        wr(2'd0, 8'hFE);
        rd(2'd0, d); check(d == 8'h02, "R2 ctrl readback", d, 8'h02);
        wr(2'd0, 8'h00);
        rd(2'd0, d); check(d == 8'h00, "R2 ctrl cleared", d, 0);
    endtask

    task automatic t_irq_period;
        int irqs, nmis, first, last, stray;
        set_intv(5);
        wr(2'd0, 8'h01);
        run_ticks(15, 0, irqs, nmis, first, last, stray);
        check(first == 5, "R5 first pulse tick", first, 5);
        check(last == 15, "R5 last pulse tick", last, 15);
        check(irqs == 3, "R5 irq periodic count", irqs, 3);
        check(nmis == 0, "R6 no nmi in irq mode", nmis, 0);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_tick_gaps;
        int irqs, nmis, first, last, stray;
        set_intv(4);
        wr(2'd0, 8'h01);
        run_ticks(8, 3, irqs, nmis, first, last, stray);
        check(first == 4 && irqs == 2, "R4 ticks only count", first, 4);
        check(stray == 0, "R4 idle cycles no pulse", stray, 0);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_nmi;
        int irqs, nmis, first, last, stray;
        set_intv(3);
        wr(2'd0, 8'h03);
        run_ticks(6, 1, irqs, nmis, first, last, stray);
        check(nmis == 2 && first == 3, "R6 nmi pulses", nmis, 2);
        check(irqs == 0, "R6 no irq in nmi mode", irqs, 0);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_restart;
        int irqs, nmis, first, last, stray;
        set_intv(6);
        wr(2'd0, 8'h01);
        run_ticks(4, 0, irqs, nmis, first, last, stray);
        wr(2'd0, 8'h01);
        run_ticks(2, 0, irqs, nmis, first, last, stray);
        check(first == 2, "R7 rewrite while running keeps count", first, 2);
        run_ticks(3, 0, irqs, nmis, first, last, stray);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h01);
        run_ticks(6, 0, irqs, nmis, first, last, stray);
        check(first == 6 && irqs == 1, "R7 restart clears count", first, 6);
        // enable write with tick in the same cycle: that tick is not counted
        wr(2'd0, 8'h00);
        @(negedge clk);
        wr_en = 1'b1; addr = 2'd0; wr_data = 8'h01; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        run_ticks(6, 0, irqs, nmis, first, last, stray);
        check(first == 6, "R7 tick during enable ignored", first, 6);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_disabled;
        int irqs, nmis, first, last, stray;
        set_intv(2);
        wr(2'd0, 8'h02);
        run_ticks(20, 0, irqs, nmis, first, last, stray);
        check(irqs + nmis == 0, "R8 disabled no pulse", irqs + nmis, 0);
    endtask

    task automatic t_zero;
        int irqs, nmis, first, last, stray;
        set_intv(0);
        wr(2'd0, 8'h01);
        run_ticks(40, 0, irqs, nmis, first, last, stray);
        check(irqs + nmis == 0, "R9 zero interval no pulse", irqs + nmis, 0);
        wr(2'd0, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regs;
        t_irq_period;
        t_tick_gaps;
        t_nmi;
        t_restart;
        t_disabled;
        t_zero;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule